// File: doc/BRIEF.md
# Dual-Mode GPIO Controller

This block drives six general-purpose pads. Each pad has its own direction and can be steered by one of two sources. In software mode, registers behind an APB slave port set the pad. In hardware mode, a dedicated control port from neighbouring logic sets the pad's value and output enable directly.

Incoming pad levels cross a two-flop synchronizer before any register read or event detection. Each pin has its own interrupt sense setting: rising edge, falling edge or high level. Edge events are held until software clears them, and one combined interrupt line reports every enabled event.

Writes and reads to the data register take a per-pin mask from address bits [7:2]. Software can therefore change or sample any subset of pins in a single access, without a read-modify-write.

Top module: `dm_gpio`

## Requirements
- R1: After a synchronous reset, pad_oe, pad_out and irq are 0, and the direction, mode, enable, sense and status registers read back as 0.
- R2: A pin in software mode has pad_oe equal to its bit of the direction register at address 0x400 (1 = output). The pad output registers update one cycle after the register changes.
- R3: A write with PADDR[10]=0 updates the output-data bit of pin i only when PADDR[2+i] is 1. All other output-data bits keep their value. A pin in software mode drives its output-data bit on pad_out.
- R4: A read with PADDR[10]=0 returns, for each pin i, the synchronized pad level if PADDR[2+i] is 1, and 0 otherwise. Bits above bit 5 read as 0.
- R5: When bit i of the mode register at 0x404 is 1, pad_out[i] and pad_oe[i] follow hw_out[i] and hw_oe[i]. When the bit returns to 0, the stored software values drive the pin again.
- R6: The sense register at 0x40C holds two bits per pin (bits 2i+1:2i). Code 00 selects rising edge and 01 selects falling edge. In an edge mode, a status bit is set only by an edge of the chosen polarity, and it stays set until cleared.
- R7: With sense code 1x (level), the status bit follows the synchronized pad level, and writing to the clear register has no effect on it.
- R8: Writing to the clear register at 0x414 clears each edge status bit whose data bit is 1. Bits written as 0 are left alone. A new edge in the same cycle as a clear of that bit leaves the bit set.
- R9: The status register at 0x410 records events regardless of the enable register at 0x408. irq is 1 exactly when some status bit is 1 and its enable bit is 1, delayed by one register stage.
- R10: Every access completes with no wait state: pready is 1 and pslverr is 0. The direction, mode, enable and sense registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| hw_out | input | 6 | Hardware-mode pad value |
| hw_oe | input | 6 | Hardware-mode output enable |
| pad_in | input | 6 | Pad input levels (asynchronous) |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The most delicate coincidence is a clear write that commits on the same clock edge on which a freshly synchronized rising edge would set the same status bit. The bench changes the pad level on one falling clock edge and starts the clear write on the next falling edge, so that the access phase lands on the setting edge. It then judges by reading the status back and expecting the bit to still be set. The outcome is contrasted with a plain clear issued later, which must empty the bit.

// File: rtl/dm_gpio_pkg.sv
package dm_gpio_pkg;
  // control register window select and word index
  localparam int CTRL_BIT = 10;
  localparam int IDX_LSB  = 2;
  localparam logic [2:0] IX_DIR   = 3'd0;
  localparam logic [2:0] IX_MODE  = 3'd1;
  localparam logic [2:0] IX_IE    = 3'd2;
  localparam logic [2:0] IX_SENSE = 3'd3;
  localparam logic [2:0] IX_STAT  = 3'd4;
  localparam logic [2:0] IX_CLR   = 3'd5;
  // sense codes: bit1 set selects level, else bit0 picks polarity
  localparam logic [1:0] SN_RISE = 2'b00;
  localparam logic [1:0] SN_FALL = 2'b01;
endpackage

// File: rtl/dm_gpio_sync.sv
module dm_gpio_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dm_gpio_evt.sv
module dm_gpio_evt (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] sense,
  input  logic       clr,
  output logic       st
);
  logic prev;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= din;
  end

  always_comb begin
    if (sense[1])      hit = 1'b0;
    else if (sense[0]) hit = prev & ~din;
    else               hit = din & ~prev;
  end

  always_ff @(posedge clk) begin
    if (rst)           st <= 1'b0;
    else if (sense[1]) st <= din;
    else if (hit)      st <= 1'b1;
    else if (clr)      st <= 1'b0;
  end

  // R8: a detected edge wins over a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    hit |=> st);
  // R6: edge status holds until a clear arrives
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (st && !clr && !sense[1]) |=> st);
  // R7: level status tracks the synchronized input
  a_r7_level: assert property (@(posedge clk) disable iff (rst)
    sense[1] |=> (st == $past(din)));
endmodule

// File: rtl/dm_gpio_regs.sv
module dm_gpio_regs
  import dm_gpio_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [AW-1:0]      paddr,
  input  logic [DW-1:0]      pwdata,
  input  logic [NPINS-1:0]   pin_sync,
  input  logic [NPINS-1:0]   status,
  output logic [DW-1:0]      prdata,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   mode_q,
  output logic [NPINS-1:0]   dout_q,
  output logic [NPINS-1:0]   ie_q,
  output logic [2*NPINS-1:0] sense_q,
  output logic [NPINS-1:0]   clr_pulse
);
  logic             wr_acc;
  logic             rd_setup;
  logic             ctrl_sel;
  logic [2:0]       idx;
  logic [NPINS-1:0] amask;
  logic [DW-1:0]    rmux;

  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign ctrl_sel = paddr[CTRL_BIT];
  assign idx      = paddr[IDX_LSB +: 3];
  assign amask    = paddr[IDX_LSB +: NPINS];

  assign clr_pulse = (wr_acc && ctrl_sel && idx == IX_CLR) ? pwdata[NPINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      mode_q  <= '0;
      dout_q  <= '0;
      ie_q    <= '0;
      sense_q <= '0;
    end else if (wr_acc) begin
      if (!ctrl_sel) begin
        dout_q <= (dout_q & ~amask) | (pwdata[NPINS-1:0] & amask);
      end else begin
        case (idx)
          IX_DIR:   dir_q   <= pwdata[NPINS-1:0];
          IX_MODE:  mode_q  <= pwdata[NPINS-1:0];
          IX_IE:    ie_q    <= pwdata[NPINS-1:0];
          IX_SENSE: sense_q <= pwdata[2*NPINS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (!ctrl_sel) begin
      rmux[NPINS-1:0] = pin_sync & amask;
    end else begin
      case (idx)
        IX_DIR:   rmux[NPINS-1:0]   = dir_q;
        IX_MODE:  rmux[NPINS-1:0]   = mode_q;
        IX_IE:    rmux[NPINS-1:0]   = ie_q;
        IX_SENSE: rmux[2*NPINS-1:0] = sense_q;
        IX_STAT:  rmux[NPINS-1:0]   = status;
        default:  rmux = '0;
      endcase
    end
  end

  // read data is captured in the setup phase, valid in the access phase
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rmux;
  end

  // R3: a masked data write leaves unmasked bits untouched
  a_r3_mask_keep: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && !ctrl_sel) |=> (((dout_q ^ $past(dout_q)) & ~$past(amask)) == '0));
  // R4: masked-out pins read as zero
  a_r4_read_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && !ctrl_sel) |=> ((prdata[NPINS-1:0] & ~$past(amask)) == '0));
endmodule

// File: rtl/dm_gpio.sv
module dm_gpio
  import dm_gpio_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic [NPINS-1:0] hw_out,
  input  logic [NPINS-1:0] hw_oe,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic [NPINS-1:0]   pin_sync;
  logic [NPINS-1:0]   status;
  logic [NPINS-1:0]   dir_q, mode_q, dout_q, ie_q, clr_pulse;
  logic [2*NPINS-1:0] sense_q;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  dm_gpio_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  dm_gpio_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pin_sync  (pin_sync),
    .status    (status),
    .prdata    (prdata),
    .dir_q     (dir_q),
    .mode_q    (mode_q),
    .dout_q    (dout_q),
    .ie_q      (ie_q),
    .sense_q   (sense_q),
    .clr_pulse (clr_pulse)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_evt
    dm_gpio_evt u_evt (
      .clk   (clk),
      .rst   (rst),
      .din   (pin_sync[i]),
      .sense (sense_q[2*i +: 2]),
      .clr   (clr_pulse[i]),
      .st    (status[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      irq     <= 1'b0;
    end else begin
      pad_out <= (mode_q & hw_out) | (~mode_q & dout_q);
      pad_oe  <= (mode_q & hw_oe)  | (~mode_q & dir_q);
      irq     <= |(status & ie_q);
    end
  end

  // R1: reset leaves every pad as an input with no interrupt
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && !irq));
  // R5: hardware-mode pins follow the control port
  a_r5_hw_path: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out ^ $past(hw_out)) & $past(mode_q)) == '0));
  // R9: no enabled status means no interrupt next cycle
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status & ie_q) == '0) |=> !irq);
endmodule

// File: tb/dm_gpio_bench.sv
module dm_gpio_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [5:0]  hw_out = '0, hw_oe = '0, pad_in = '0;
  logic [5:0]  pad_out, pad_oe;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_DIR = 12'h400, A_MODE = 12'h404, A_IE = 12'h408,
                          A_SENSE = 12'h40C, A_STAT = 12'h410, A_CLR = 12'h414;

  always #10 clk = ~clk;

  dm_gpio u_dm_gpio (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .hw_out(hw_out), .hw_oe(hw_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pad_oe", {26'd0, pad_oe}, 32'h0);
    chk("R1 pad_out", {26'd0, pad_out}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    apb_rd(A_DIR, v);   chk("R1 dir", v, 32'h0);
    apb_rd(A_MODE, v);  chk("R1 mode", v, 32'h0);
    apb_rd(A_SENSE, v); chk("R1 sense", v, 32'h0);
    apb_rd(A_STAT, v);  chk("R1 status", v, 32'h0);
    chk("R10 pready", {31'd0, pready}, 32'h1);
    chk("R10 pslverr", {31'd0, pslverr}, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    apb_wr(A_DIR, 32'h2D);
    idle(2);
    chk("R2 pad_oe", {26'd0, pad_oe}, 32'h2D);
    apb_rd(A_DIR, v); chk("R10 dir readback", v, 32'h2D);
  endtask

  task automatic t_masked_write();
    apb_wr({4'h0, 6'h3F, 2'b00}, 32'h3F);
    idle(2); chk("R3 full write", {26'd0, pad_out}, 32'h3F);
    apb_wr({4'h0, 6'h05, 2'b00}, 32'h00);
    idle(2); chk("R3 mask 05", {26'd0, pad_out}, 32'h3A);
    apb_wr({4'h0, 6'h30, 2'b00}, 32'h3F & 32'h10);
    idle(2); chk("R3 mask 30", {26'd0, pad_out}, 32'h1A);
  endtask

  task automatic t_masked_read();
    logic [31:0] v;
    pad_in = 6'h2B;
    idle(4);
    apb_rd({4'h0, 6'h0F, 2'b00}, v); chk("R4 mask 0F", v, 32'h0B);
    apb_rd({4'h0, 6'h3F, 2'b00}, v); chk("R4 mask 3F", v, 32'h2B);
    apb_rd({4'h0, 6'h00, 2'b00}, v); chk("R4 mask 00", v, 32'h0);
  endtask

  task automatic t_hw();
    logic [31:0] v;
    hw_out = 6'h01; hw_oe = 6'h03;
    apb_wr(A_MODE, 32'h03);
    idle(2);
    chk("R5 hw pad_out", {26'd0, pad_out}, 32'h19);
    chk("R5 hw pad_oe", {26'd0, pad_oe}, 32'h2F);
    hw_out = 6'h02;
    idle(2);
    chk("R5 hw follows", {26'd0, pad_out}, 32'h1A);
    apb_rd(A_MODE, v); chk("R10 mode readback", v, 32'h03);
    apb_wr(A_MODE, 32'h00);
    idle(2);
    chk("R5 sw restore out", {26'd0, pad_out}, 32'h1A);
    chk("R5 sw restore oe", {26'd0, pad_oe}, 32'h2D);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    apb_wr(A_SENSE, 32'h24);
    apb_rd(A_SENSE, v); chk("R10 sense readback", v, 32'h24);
    pad_in = 6'h00; idle(6);
    apb_wr(A_CLR, 32'h3F);
    apb_rd(A_STAT, v); chk("R6 cleared start", v, 32'h0);
    pad_in = 6'h01; idle(5);
    apb_rd(A_STAT, v); chk("R6 rise sets", v, 32'h01);
    pad_in = 6'h00; idle(5);
    apb_rd(A_STAT, v); chk("R6 sticky", v, 32'h01);
    pad_in = 6'h02; idle(5);
    apb_rd(A_STAT, v); chk("R6 wrong polarity", v, 32'h01);
    pad_in = 6'h00; idle(5);
    apb_rd(A_STAT, v); chk("R6 fall sets", v, 32'h03);
    pad_in = 6'h04; idle(5);
    apb_rd(A_STAT, v); chk("R7 level high", v, 32'h07);
    apb_wr(A_CLR, 32'h04); idle(1);
    apb_rd(A_STAT, v); chk("R7 clear ignored", v, 32'h07);
    pad_in = 6'h00; idle(5);
    apb_rd(A_STAT, v); chk("R7 level low", v, 32'h03);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    apb_wr(A_CLR, 32'h01);
    apb_rd(A_STAT, v); chk("R8 partial clear", v, 32'h02);
    apb_wr(A_CLR, 32'h02);
    apb_rd(A_STAT, v); chk("R8 full clear", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    apb_wr(A_IE, 32'h01);
    apb_rd(A_IE, v); chk("R10 ie readback", v, 32'h01);
    idle(2); chk("R9 idle irq", {31'd0, irq}, 32'h0);
    pad_in = 6'h01; idle(6);
    chk("R9 irq raised", {31'd0, irq}, 32'h1);
    apb_wr(A_IE, 32'h00); idle(2);
    chk("R9 irq masked", {31'd0, irq}, 32'h0);
    pad_in = 6'h03; idle(5);
    pad_in = 6'h01; idle(5);
    chk("R9 disabled pin quiet", {31'd0, irq}, 32'h0);
    apb_rd(A_STAT, v); chk("R9 status recorded", v, 32'h03);
    apb_wr(A_CLR, 32'h3F);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pad_in = 6'h00; idle(5);
    apb_wr(A_CLR, 32'h3F);
    apb_rd(A_STAT, v); chk("R8 race pre", v, 32'h0);
    @(negedge clk); pad_in = 6'h01;
    apb_wr(A_CLR, 32'h01);
    idle(3);
    apb_rd(A_STAT, v); chk("R8 set wins", v, 32'h01);
    apb_wr(A_CLR, 32'h01);
    apb_rd(A_STAT, v); chk("R8 later clear", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dir();
    t_masked_write();
    t_masked_read();
    t_hw();
    t_edges();
    t_w1c();
    t_irq();
    t_race();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule